// File: doc/BRIEF.md
# Interrupt Acceptance and Flush Controller

This block decides when a core may take an asynchronous external interrupt. The raw request pin first passes through a short synchronizer. The block then looks at the oldest completion-queue entry. In the usual case it accepts the request at once, drives a one-cycle flush of all in-flight work, and on the next cycle drives a one-cycle redirect that carries the handler fetch address.

Two kinds of oldest entry cannot be interrupted: a guarded load and a cache-inhibited store-conditional. When one of them is oldest, the block allows that entry to retire and waits for the bus to finish it. Delivery then depends on memory latency and has no fixed bound. A bus error ends the wait as well: the entry is abandoned and the interrupt is taken. Once a request has been accepted, pin activity has no effect until the redirect has been issued.

Top module: `irq_flush_ctl`

## Requirements
- R1: After reset, `flushPulse` and `redirectPulse` are 0, `handlerVec` is 0 and `allowRetire` is 1.
- R2: The pin passes through two synchronizer flops. A rise on `irqPin` before rising edge k can first produce `flushPulse` after edge k+2, and no earlier.
- R3: If the oldest entry is not special (`oldValid`=0, or `oldClass` is 0 or 3), `flushPulse` is high for exactly one cycle. `redirectPulse` follows in the next cycle for exactly one cycle. The redirect comes 2 cycles after the synchronized request is first sampled, within the bound of 8.
- R4: `handlerVec` equals the parameter `HANDLER_VEC` while `redirectPulse` is high, and is 0 at all other times.
- R5: A special oldest entry is `oldValid`=1 with `oldClass`=1 (guarded load) or `oldClass`=2 (cache-inhibited store-conditional). While such an entry is oldest and a request is pending, no flush is issued and `allowRetire` stays 1 until `busDone` or `busErr` is seen. `flushPulse` follows in the next cycle.
- R6: A `busErr` seen during the wait drives `allowRetire` to 0 in that same cycle, because the entry is abandoned, and the flush follows in the next cycle.
- R7: `allowRetire` is 0 during the flush and redirect cycles. It is also 0 in the cycle a synchronized request is accepted over a non-special oldest entry.
- R8: After a request is accepted, changes on `irqPin` have no effect until the redirect has been issued. If the pin is low by then, no further flush occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irqPin | input | 1 | Raw asynchronous interrupt request, level sensitive |
| oldValid | input | 1 | Oldest completion-queue slot holds an entry |
| oldClass | input | 2 | Class of the oldest entry: 0 plain, 1 guarded load, 2 cache-inhibited store-conditional, 3 other |
| busDone | input | 1 | Bus has completed the oldest entry's access |
| busErr | input | 1 | Bus has ended the oldest entry's access with an error |
| flushPulse | output | 1 | One-cycle flush of all in-flight work |
| redirectPulse | output | 1 | One-cycle handler fetch redirect |
| handlerVec | output | 32 | Handler address, valid with `redirectPulse` |
| allowRetire | output | 1 | Oldest entry may retire this cycle |

## Verification
The hardest situation to reach from the ports is the unbounded wait. It needs a request to arrive while a special entry is oldest, and the pin must then toggle during the wait. The wait must also end through the error path instead of normal completion. The stimulus sweeps every oldest-entry class with the valid flag set and cleared. For each special case it varies the wait length and toggles the pin on every waiting cycle. Each wait ends once with `busDone` and once with `busErr`, and the bench checks that the retire permission drops in the same cycle as an error.

// File: rtl/irq_flush_pkg.sv
package irq_flush_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_FLUSH = 2'd2,
    ST_REDIR = 2'd3
  } irqState_e;

  typedef struct packed {
    logic flush;
    logic redirect;
    logic retireOk;
  } ctlStrobe_t;

  localparam int CLASS_W = 2;
  localparam logic [CLASS_W-1:0] CLS_GUARDED_LD = 2'd1;
  localparam logic [CLASS_W-1:0] CLS_CI_STCOND  = 2'd2;
endpackage

// File: rtl/irq_flush_dp.sv
module irq_flush_dp
  import irq_flush_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int VEC_W = 32,
  parameter logic [VEC_W-1:0] HANDLER_VEC = 32'h0000_0500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irqPin,
  input  ctlStrobe_t       strobe,
  output logic             irqSync,
  output logic             flushPulse,
  output logic             redirectPulse,
  output logic [VEC_W-1:0] handlerVec,
  output logic             allowRetire
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic [VEC_W-1:0]       vecReg;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rst_n) syncChain <= '0;
        else        syncChain <= irqPin;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rst_n) syncChain <= '0;
        else        syncChain <= {syncChain[SYNC_STAGES-2:0], irqPin};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) vecReg <= HANDLER_VEC;
    else        vecReg <= vecReg;
  end

  assign irqSync       = syncChain[LAST];
  assign flushPulse    = strobe.flush;
  assign redirectPulse = strobe.redirect;
  assign allowRetire   = strobe.retireOk;
  assign handlerVec    = strobe.redirect ? vecReg : '0;
endmodule

// File: rtl/irq_flush_fsm.sv
module irq_flush_fsm
  import irq_flush_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               irqSync,
  input  logic               oldValid,
  input  logic [CLASS_W-1:0] oldClass,
  input  logic               busDone,
  input  logic               busErr,
  output ctlStrobe_t         strobe
);
  irqState_e state, nextState;
  logic specialOldest;

  assign specialOldest = oldValid &&
                         (oldClass == CLS_GUARDED_LD || oldClass == CLS_CI_STCOND);

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        strobe.retireOk = !irqSync || specialOldest;
        if (irqSync) nextState = specialOldest ? ST_WAIT : ST_FLUSH;
      end
      ST_WAIT: begin
        strobe.retireOk = !busErr;
        if (busDone || busErr) nextState = ST_FLUSH;
      end
      ST_FLUSH: begin
        strobe.flush = 1'b1;
        nextState    = ST_REDIR;
      end
      ST_REDIR: begin
        strobe.redirect = 1'b1;
        nextState       = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end
endmodule

// File: rtl/irq_flush_ctl.sv
module irq_flush_ctl
  import irq_flush_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int VEC_W = 32,
  parameter logic [VEC_W-1:0] HANDLER_VEC = 32'h0000_0500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irqPin,
  input  logic             oldValid,
  input  logic [1:0]       oldClass,
  input  logic             busDone,
  input  logic             busErr,
  output logic             flushPulse,
  output logic             redirectPulse,
  output logic [VEC_W-1:0] handlerVec,
  output logic             allowRetire
);
  ctlStrobe_t strobe;
  logic       irqSync;

  irq_flush_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .irqSync(irqSync), .oldValid(oldValid),
    .oldClass(oldClass), .busDone(busDone), .busErr(busErr), .strobe(strobe)
  );

  irq_flush_dp #(
    .SYNC_STAGES(SYNC_STAGES), .VEC_W(VEC_W), .HANDLER_VEC(HANDLER_VEC)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .irqPin(irqPin), .strobe(strobe),
    .irqSync(irqSync), .flushPulse(flushPulse), .redirectPulse(redirectPulse),
    .handlerVec(handlerVec), .allowRetire(allowRetire)
  );
endmodule

// File: rtl/irq_flush_ctl_chk.sv
module irq_flush_ctl_chk #(
  parameter int VEC_W = 32,
  parameter logic [VEC_W-1:0] HANDLER_VEC = 32'h0000_0500
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busErr,
  input logic             flushPulse,
  input logic             redirectPulse,
  input logic [VEC_W-1:0] handlerVec,
  input logic             allowRetire
);
  a_r3_flush_then_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    flushPulse |=> redirectPulse);
  a_r3_single_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flushPulse |=> !flushPulse);
  a_r3_single_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    redirectPulse |=> !redirectPulse);
  a_r4_vector_on_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    redirectPulse |-> handlerVec == HANDLER_VEC);
  a_r4_vector_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !redirectPulse |-> handlerVec == '0);
  a_r7_no_retire_in_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (flushPulse || redirectPulse) |-> !allowRetire);
  a_r3_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(flushPulse && redirectPulse));
  a_r6_err_then_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (busErr && !allowRetire && !flushPulse && !redirectPulse) |=> flushPulse);
endmodule

bind irq_flush_ctl irq_flush_ctl_chk #(.VEC_W(VEC_W), .HANDLER_VEC(HANDLER_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .busErr(busErr), .flushPulse(flushPulse),
  .redirectPulse(redirectPulse), .handlerVec(handlerVec), .allowRetire(allowRetire)
);

// File: tb/irq_flush_ctl_bench.sv
`timescale 1ns/1ps
module irq_flush_ctl_bench;
  localparam logic [31:0] VEC = 32'h0000_0500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irqPin = 1'b0, oldValid = 1'b0, busDone = 1'b0, busErr = 1'b0;
  logic [1:0] oldClass = 2'd0;
  logic flushPulse, redirectPulse, allowRetire;
  logic [31:0] handlerVec;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  irq_flush_ctl u_irq_flush_ctl (
    .clk(clk), .rst_n(rst_n), .irqPin(irqPin), .oldValid(oldValid),
    .oldClass(oldClass), .busDone(busDone), .busErr(busErr),
    .flushPulse(flushPulse), .redirectPulse(redirectPulse),
    .handlerVec(handlerVec), .allowRetire(allowRetire)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idleCheck(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R8 no extra flush", {31'd0, flushPulse}, 32'd0);
      chk("R8 no extra redirect", {31'd0, redirectPulse}, 32'd0);
    end
  endtask

  task automatic runIrq(input int cls, input int valid, input int delay, input int useErr);
    logic special;
    special = (valid == 1) && (cls == 1 || cls == 2);
    @(negedge clk);
    oldClass = cls[1:0];
    oldValid = valid[0];
    irqPin = 1'b1;
    @(negedge clk);
    chk("R2 no flush after one edge", {31'd0, flushPulse}, 32'd0);
    @(negedge clk);
    chk("R2 no flush after two edges", {31'd0, flushPulse}, 32'd0);
    chk("R7 retire in accept cycle", {31'd0, allowRetire}, {31'd0, special});
    @(negedge clk);
    if (!special) begin
      chk("R3 flush on third edge", {31'd0, flushPulse}, 32'd1);
      chk("R7 no retire in flush", {31'd0, allowRetire}, 32'd0);
      irqPin = 1'b0;
      @(negedge clk);
      chk("R3 redirect follows flush", {31'd0, redirectPulse}, 32'd1);
      chk("R4 vector on redirect", handlerVec, VEC);
      chk("R7 no retire in redirect", {31'd0, allowRetire}, 32'd0);
      chk("R3 flush single cycle", {31'd0, flushPulse}, 32'd0);
    end else begin
      chk("R5 no flush while special oldest", {31'd0, flushPulse}, 32'd0);
      chk("R5 retire allowed in wait", {31'd0, allowRetire}, 32'd1);
      for (int d = 0; d < delay; d++) begin
        irqPin = ~irqPin;
        @(negedge clk);
        chk("R5 still waiting", {31'd0, flushPulse}, 32'd0);
        chk("R5 retire held in wait", {31'd0, allowRetire}, 32'd1);
        chk("R4 vector zero in wait", handlerVec, 32'd0);
      end
      irqPin = 1'b0;
      if (useErr == 1) busErr = 1'b1; else busDone = 1'b1;
      #1;
      if (useErr == 1) chk("R6 error blocks retire", {31'd0, allowRetire}, 32'd0);
      else             chk("R5 retire on bus done", {31'd0, allowRetire}, 32'd1);
      @(negedge clk);
      busErr = 1'b0;
      busDone = 1'b0;
      chk(useErr == 1 ? "R6 flush after error" : "R5 flush after done",
          {31'd0, flushPulse}, 32'd1);
      @(negedge clk);
      chk("R3 redirect after wait", {31'd0, redirectPulse}, 32'd1);
      chk("R4 vector after wait", handlerVec, VEC);
    end
    idleCheck(3);
    chk("R4 vector zero when idle", handlerVec, 32'd0);
    chk("R1 idle retire", {31'd0, allowRetire}, 32'd1);
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset flush", {31'd0, flushPulse}, 32'd0);
    chk("R1 reset redirect", {31'd0, redirectPulse}, 32'd0);
    chk("R1 reset vector", handlerVec, 32'd0);
    chk("R1 reset retire", {31'd0, allowRetire}, 32'd1);
    for (int c = 0; c < 4; c++)
      for (int v = 0; v < 2; v++)
        for (int d = 0; d < 4; d++)
          for (int e = 0; e < 2; e++)
            runIrq(c, v, d, e);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule